// File: doc/BRIEF.md
# Coalesced Interrupt EOI Tracker

This block keeps the acknowledgement state for one tracked interrupt source, typically a periodic timer line. When the interrupt controller reports a delivery of that source, the block records which destinations accepted it and the vector each destination received. It also loads a counter with the number of accepting destinations. Each destination later signals end-of-interrupt (EOI) with its own ID and a vector. An EOI retires that destination only when the destination is still marked and the vector matches the one it was given.

While any acknowledgement is outstanding, a new assertion of the tracked source is flagged as coalesced, so the upstream logic can drop it rather than deliver it again. Delivery reports that arrive while acknowledgements are outstanding are ignored. A clear input returns the tracker to idle. How destinations are chosen lies outside this block; it consumes only the resulting accept bitmap.

Top module: `eoi_coalesce_tracker`

## Requirements
- R1: After reset is asserted, the pending count is 0, the pending map is all zeros and the error flag is 0, so `coalesced_o` is 0 even when `req_i` is 1.
- R2: A delivery report (`dlv_valid_i`) accepted while the count is 0 sets the pending map to `dlv_mask_i` and the count to the number of ones in it, visible after the next rising edge. A mask of all zeros (failed delivery) leaves the count at 0. A full mask gives the maximum count, equal to NUM_DEST.
- R3: A matching EOI clears that destination's bit (bit index = `eoi_dest_i`) and decrements the count by one at the next edge. An EOI matches when its destination's bit is set and `eoi_vec_i` equals the vector stored for that destination at its last accepted delivery.
- R4: An EOI from a destination whose bit is clear, or one carrying a vector that differs from the stored one, changes neither the map nor the count. This includes a stale vector from an earlier delivery.
- R5: `coalesced_o` is 1 in the same cycle exactly when `req_i` is 1 and the count is nonzero.
- R6: `clr_i` zeroes the count, the map and the error flag at the next edge, and it takes priority over a delivery or EOI in the same cycle.
- R7: A delivery report that arrives while the count, after any same-cycle EOI, is nonzero is ignored. The map, the count and the stored vectors keep their values.
- R8: When an EOI and a delivery report arrive in the same cycle, the EOI is applied first. If it brings the count to zero, the delivery is accepted in that same cycle.
- R9: The count always equals the number of ones in the pending map. If an EOI would take the count below zero, the block sets `err_o` and rebuilds the count from the map. `err_o` stays 0 in every legal sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clear all tracking state |
| dlv_valid_i | input | 1 | Delivery result of the tracked source is valid |
| dlv_mask_i | input | NUM_DEST | Destinations that accepted the delivery |
| dlv_vec_i | input | VEC_W | Vector delivered |
| eoi_valid_i | input | 1 | EOI strobe |
| eoi_dest_i | input | ID_W | Destination issuing the EOI |
| eoi_vec_i | input | VEC_W | Vector being acknowledged |
| req_i | input | 1 | New assertion of the tracked source |
| coalesced_o | output | 1 | Assertion must be dropped as coalesced |
| pend_cnt_o | output | CNT_W | Outstanding acknowledgement count |
| pend_map_o | output | NUM_DEST | Destinations still owing an EOI |
| err_o | output | 1 | Count underflow was detected and repaired |

## Verification
If a stored vector is wrong, the first EOI from that destination is ignored. The count and map then fail to drop one edge after the EOI. If the count or map is corrupted, the two outputs drift apart at once, so the count no longer equals the map's population. A stuck nonzero count shows up in the same cycle as a spurious `coalesced_o` on the next request. A wrong priority between clear, EOI and delivery appears one edge after the colliding cycle, either as a map that does not match the expected one or as a rejected delivery.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;

  // Cause of the next-state update of the pending state.
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_EOI   = 2'd1,
    UPD_LOAD  = 2'd2,
    UPD_CLEAR = 2'd3
  } upd_cause_e;

  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/eoi_trk_vec_bank.sv
module eoi_trk_vec_bank #(
  parameter int unsigned NUM_DEST = 16,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned ID_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DEST-1:0] wr_en,
  input  logic [VEC_W-1:0]    wr_vec,
  input  logic [ID_W-1:0]     rd_idx,
  output logic [VEC_W-1:0]    rd_vec
);

  localparam int unsigned FLAT_W = NUM_DEST * VEC_W;

  logic [FLAT_W-1:0] slots_flat;

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_slot
    logic [VEC_W-1:0] slot_q;
    logic [VEC_W-1:0] slot_d;

    always_comb begin
      slot_d = slot_q;
      if (wr_en[g]) begin
        slot_d = wr_vec;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (wr_en[g]) begin
        slot_q <= slot_d;
      end
    end

    assign slots_flat[g*VEC_W +: VEC_W] = slot_q;
  end

  always_comb begin
    rd_vec = '0;
    for (int i = 0; i < NUM_DEST; i++) begin
      if (rd_idx == ID_W'(i)) begin
        rd_vec = slots_flat[i*VEC_W +: VEC_W];
      end
    end
  end

endmodule

// File: rtl/eoi_trk_match.sv
module eoi_trk_match #(
  parameter int unsigned NUM_DEST = 16,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned ID_W     = 4
) (
  input  logic                eoi_valid,
  input  logic [ID_W-1:0]     eoi_dest,
  input  logic [VEC_W-1:0]    eoi_vec,
  input  logic [NUM_DEST-1:0] map_q,
  input  logic [VEC_W-1:0]    stored_vec,
  output logic                hit,
  output logic [NUM_DEST-1:0] hit_onehot
);

  logic in_range;
  logic bit_set;

  always_comb begin
    in_range = (int'(eoi_dest) < int'(NUM_DEST));
    bit_set  = 1'b0;
    for (int i = 0; i < NUM_DEST; i++) begin
      if (eoi_dest == ID_W'(i)) begin
        bit_set = map_q[i];
      end
    end
    hit = eoi_valid && in_range && bit_set && (stored_vec == eoi_vec);
  end

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_sel
    assign hit_onehot[g] = hit && (eoi_dest == ID_W'(g));
  end

endmodule

// File: rtl/eoi_trk_state.sv
module eoi_trk_state
  import eoi_trk_pkg::*;
#(
  parameter int unsigned NUM_DEST = 16,
  parameter int unsigned CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                hit,
  input  logic [NUM_DEST-1:0] hit_onehot,
  input  logic                dlv_valid,
  input  logic [NUM_DEST-1:0] dlv_mask,
  output logic                load_en,
  output logic [NUM_DEST-1:0] map_q,
  output logic [CNT_W-1:0]    cnt_q,
  output logic                err_q
);

  upd_cause_e          cause;
  logic [NUM_DEST-1:0] map_eoi;
  logic [CNT_W-1:0]    cnt_eoi;
  logic                underflow;
  logic [NUM_DEST-1:0] map_d;
  logic [CNT_W-1:0]    cnt_d;
  logic                err_d;
  logic                state_en;

  // EOI is resolved before any delivery of the same cycle.
  always_comb begin
    map_eoi   = map_q & ~hit_onehot;
    underflow = hit && (cnt_q == '0);
    if (!hit) begin
      cnt_eoi = cnt_q;
    end else if (underflow) begin
      cnt_eoi = CNT_W'($countones(map_eoi));
    end else begin
      cnt_eoi = cnt_q - CNT_W'(1);
    end
    load_en = dlv_valid && !clr && (cnt_eoi == '0);

    if (clr) begin
      cause = UPD_CLEAR;
    end else if (load_en) begin
      cause = UPD_LOAD;
    end else if (hit) begin
      cause = UPD_EOI;
    end else begin
      cause = UPD_HOLD;
    end
  end

  always_comb begin
    map_d = map_q;
    cnt_d = cnt_q;
    err_d = err_q;
    unique case (cause)
      UPD_CLEAR: begin
        map_d = '0;
        cnt_d = '0;
        err_d = 1'b0;
      end
      UPD_LOAD: begin
        map_d = map_eoi | dlv_mask;
        cnt_d = CNT_W'($countones(map_eoi | dlv_mask));
        err_d = err_q | underflow;
      end
      UPD_EOI: begin
        map_d = map_eoi;
        cnt_d = cnt_eoi;
        err_d = err_q | underflow;
      end
      default: begin
        map_d = map_q;
        cnt_d = cnt_q;
        err_d = err_q;
      end
    endcase
    state_en = (cause != UPD_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (state_en) begin
      map_q <= map_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/eoi_coalesce_tracker.sv
module eoi_coalesce_tracker #(
  parameter int unsigned NUM_DEST = 16,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned ID_W     = eoi_trk_pkg::id_width(NUM_DEST),
  parameter int unsigned CNT_W    = $clog2(NUM_DEST + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                dlv_valid_i,
  input  logic [NUM_DEST-1:0] dlv_mask_i,
  input  logic [VEC_W-1:0]    dlv_vec_i,
  input  logic                eoi_valid_i,
  input  logic [ID_W-1:0]     eoi_dest_i,
  input  logic [VEC_W-1:0]    eoi_vec_i,
  input  logic                req_i,
  output logic                coalesced_o,
  output logic [CNT_W-1:0]    pend_cnt_o,
  output logic [NUM_DEST-1:0] pend_map_o,
  output logic                err_o
);

  logic [VEC_W-1:0]    stored_vec;
  logic                hit;
  logic [NUM_DEST-1:0] hit_onehot;
  logic                load_en;
  logic [NUM_DEST-1:0] map_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                err_q;
  logic [NUM_DEST-1:0] vec_wr_en;

  assign vec_wr_en = load_en ? dlv_mask_i : '0;

  eoi_trk_vec_bank #(
    .NUM_DEST (NUM_DEST),
    .VEC_W    (VEC_W),
    .ID_W     (ID_W)
  ) u_vec_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (vec_wr_en),
    .wr_vec (dlv_vec_i),
    .rd_idx (eoi_dest_i),
    .rd_vec (stored_vec)
  );

  eoi_trk_match #(
    .NUM_DEST (NUM_DEST),
    .VEC_W    (VEC_W),
    .ID_W     (ID_W)
  ) u_match (
    .eoi_valid  (eoi_valid_i),
    .eoi_dest   (eoi_dest_i),
    .eoi_vec    (eoi_vec_i),
    .map_q      (map_q),
    .stored_vec (stored_vec),
    .hit        (hit),
    .hit_onehot (hit_onehot)
  );

  eoi_trk_state #(
    .NUM_DEST (NUM_DEST),
    .CNT_W    (CNT_W)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_i),
    .hit        (hit),
    .hit_onehot (hit_onehot),
    .dlv_valid  (dlv_valid_i),
    .dlv_mask   (dlv_mask_i),
    .load_en    (load_en),
    .map_q      (map_q),
    .cnt_q      (cnt_q),
    .err_q      (err_q)
  );

  assign coalesced_o = req_i && (cnt_q != '0);
  assign pend_cnt_o  = cnt_q;
  assign pend_map_o  = map_q;
  assign err_o       = err_q;

endmodule

// File: rtl/eoi_trk_checker.sv
module eoi_trk_checker #(
  parameter int unsigned NUM_DEST = 16,
  parameter int unsigned CNT_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr_i,
  input logic                dlv_valid_i,
  input logic [NUM_DEST-1:0] dlv_mask_i,
  input logic                eoi_valid_i,
  input logic [CNT_W-1:0]    pend_cnt_o,
  input logic [NUM_DEST-1:0] pend_map_o,
  input logic                err_o
);

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_i && !clr_i && !eoi_valid_i && pend_cnt_o == '0)
    |=> (pend_map_o == $past(dlv_mask_i)));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !dlv_valid_i)
    |=> ((pend_cnt_o == $past(pend_cnt_o)) ||
         (pend_cnt_o == $past(pend_cnt_o) - CNT_W'(1))));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pend_cnt_o == '0 && pend_map_o == '0 && !err_o));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_i && !clr_i && !eoi_valid_i && pend_cnt_o != '0)
    |=> ($stable(pend_cnt_o) && $stable(pend_map_o)));

  a_r9_count_sum: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt_o == CNT_W'($countones(pend_map_o)));

  a_r9_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !err_o);

endmodule

bind eoi_coalesce_tracker eoi_trk_checker #(
  .NUM_DEST (NUM_DEST),
  .CNT_W    (CNT_W)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .dlv_valid_i (dlv_valid_i),
  .dlv_mask_i  (dlv_mask_i),
  .eoi_valid_i (eoi_valid_i),
  .pend_cnt_o  (pend_cnt_o),
  .pend_map_o  (pend_map_o),
  .err_o       (err_o)
);

// File: tb/test_eoi_coalesce_tracker.sv
module test_eoi_coalesce_tracker;

  logic        clk;
  logic        rst_n;
  logic        clr_i;
  logic        dlv_valid_i;
  logic [15:0] dlv_mask_i;
  logic [7:0]  dlv_vec_i;
  logic        eoi_valid_i;
  logic [3:0]  eoi_dest_i;
  logic [7:0]  eoi_vec_i;
  logic        req_i;
  logic        coalesced_o;
  logic [4:0]  pend_cnt_o;
  logic [15:0] pend_map_o;
  logic        err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  eoi_coalesce_tracker i_eoi_coalesce_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .dlv_valid_i (dlv_valid_i),
    .dlv_mask_i  (dlv_mask_i),
    .dlv_vec_i   (dlv_vec_i),
    .eoi_valid_i (eoi_valid_i),
    .eoi_dest_i  (eoi_dest_i),
    .eoi_vec_i   (eoi_vec_i),
    .req_i       (req_i),
    .coalesced_o (coalesced_o),
    .pend_cnt_o  (pend_cnt_o),
    .pend_map_o  (pend_map_o),
    .err_o       (err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // op: 0 none, 1 delivery, 2 EOI, 3 clear
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] mask;
    logic [3:0]  dest;
    logic [7:0]  vec;
    logic [4:0]  ecnt;
    logic [15:0] emap;
  } step_t;

  localparam int NSTEP = 15;
  localparam step_t TBL [NSTEP] = '{
    '{2'd1, 16'h00A5, 4'd0,  8'h30, 5'd4,  16'h00A5},
    '{2'd2, 16'h0000, 4'd0,  8'h30, 5'd3,  16'h00A4},
    '{2'd2, 16'h0000, 4'd2,  8'h31, 5'd3,  16'h00A4},
    '{2'd2, 16'h0000, 4'd1,  8'h30, 5'd3,  16'h00A4},
    '{2'd1, 16'hFF00, 4'd0,  8'h40, 5'd3,  16'h00A4},
    '{2'd2, 16'h0000, 4'd2,  8'h30, 5'd2,  16'h00A0},
    '{2'd2, 16'h0000, 4'd5,  8'h30, 5'd1,  16'h0080},
    '{2'd2, 16'h0000, 4'd7,  8'h30, 5'd0,  16'h0000},
    '{2'd2, 16'h0000, 4'd7,  8'h30, 5'd0,  16'h0000},
    '{2'd1, 16'h0000, 4'd0,  8'h50, 5'd0,  16'h0000},
    '{2'd1, 16'hFFFF, 4'd0,  8'h51, 5'd16, 16'hFFFF},
    '{2'd3, 16'h0000, 4'd0,  8'h00, 5'd0,  16'h0000},
    '{2'd1, 16'h8001, 4'd0,  8'h60, 5'd2,  16'h8001},
    '{2'd2, 16'h0000, 4'd15, 8'h51, 5'd2,  16'h8001},
    '{2'd2, 16'h0000, 4'd15, 8'h60, 5'd1,  16'h0001}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 9, 10, 12: return "R2";
      1, 6, 7, 14:  return "R3";
      2, 3, 8, 13:  return "R4";
      4, 5:         return "R7";
      default:      return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    clr_i       = 1'b0;
    dlv_valid_i = 1'b0;
    dlv_mask_i  = '0;
    dlv_vec_i   = '0;
    eoi_valid_i = 1'b0;
    eoi_dest_i  = '0;
    eoi_vec_i   = '0;
    req_i       = 1'b0;
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic cycle();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_state(input string tag, input logic [4:0] ecnt,
                             input logic [15:0] emap);
    check(tag, "count", 32'(pend_cnt_o), 32'(ecnt));
    check(tag, "map",   32'(pend_map_o), 32'(emap));
    check("R9", "count vs map", 32'(pend_cnt_o), 32'($countones(pend_map_o)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R5 no coalescing when idle
    req_i = 1'b1;
    #1;
    check("R1", "count", 32'(pend_cnt_o), 32'd0);
    check("R1", "map",   32'(pend_map_o), 32'd0);
    check("R1", "err",   32'(err_o), 32'd0);
    check("R5", "coalesced idle", 32'(coalesced_o), 32'd0);
    req_i = 1'b0;

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      case (TBL[i].op)
        2'd1: begin
          dlv_valid_i = 1'b1;
          dlv_mask_i  = TBL[i].mask;
          dlv_vec_i   = TBL[i].vec;
        end
        2'd2: begin
          eoi_valid_i = 1'b1;
          eoi_dest_i  = TBL[i].dest;
          eoi_vec_i   = TBL[i].vec;
        end
        2'd3: clr_i = 1'b1;
        default: ;
      endcase
      cycle();
      check_state(row_tag(i), TBL[i].ecnt, TBL[i].emap);
    end

    // R5: count is 1 here
    req_i = 1'b1;
    #1;
    check("R5", "coalesced busy", 32'(coalesced_o), 32'd1);
    req_i = 1'b0;
    #1;
    check("R5", "no request", 32'(coalesced_o), 32'd0);

    // R8: EOI retires the last destination, delivery accepted in same cycle
    @(negedge clk);
    eoi_valid_i = 1'b1; eoi_dest_i = 4'd0; eoi_vec_i = 8'h60;
    dlv_valid_i = 1'b1; dlv_mask_i = 16'h0006; dlv_vec_i = 8'h70;
    cycle();
    check_state("R8", 5'd2, 16'h0006);

    // R8/R7: EOI leaves one outstanding, so the delivery is ignored
    @(negedge clk);
    eoi_valid_i = 1'b1; eoi_dest_i = 4'd1; eoi_vec_i = 8'h70;
    dlv_valid_i = 1'b1; dlv_mask_i = 16'h0100; dlv_vec_i = 8'h71;
    cycle();
    check_state("R8", 5'd1, 16'h0004);

    // R6: clear beats same-cycle EOI and delivery
    @(negedge clk);
    clr_i = 1'b1;
    eoi_valid_i = 1'b1; eoi_dest_i = 4'd2; eoi_vec_i = 8'h70;
    dlv_valid_i = 1'b1; dlv_mask_i = 16'h0003; dlv_vec_i = 8'h72;
    cycle();
    check_state("R6", 5'd0, 16'h0000);
    check("R9", "err", 32'(err_o), 32'd0);

    // R1: reset in the middle of a pending delivery
    @(negedge clk);
    dlv_valid_i = 1'b1; dlv_mask_i = 16'h0F0F; dlv_vec_i = 8'h80;
    cycle();
    check_state("R2", 5'd8, 16'h0F0F);
    rst_n = 1'b0;
    #1;
    check("R1", "count after reset", 32'(pend_cnt_o), 32'd0);
    check("R1", "map after reset", 32'(pend_map_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req_i = 1'b1;
    #1;
    check("R1", "coalesced after reset", 32'(coalesced_o), 32'd0);
    req_i = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule